// File: doc/BRIEF.md
# Five-stage pipelined eight-register core

This block is a single-issue, in-order processor core for a compact instruction set of 32-bit words with eight general registers. Every instruction passes through five stages in order: fetch, decode, execute, memory access and write-back. Instruction and data storage are separate word-addressed memories with 16-bit addresses. Inside the core are the register file, the ALU, operand forwarding from the two stage registers that follow execute, a one-cycle interlock for a load followed by a dependent instruction, and branch handling that decides late and squashes younger work.

Branches are assumed not taken. A `beq` or `jalr` is resolved once it sits in the memory stage, and the three younger instructions are then thrown away. When a `halt` reaches write-back, the core freezes and raises `halted`. Before reset is released, the environment fills both memories through a small load port. The same port, together with a register peek input, reads state back after the program ends.

Top module: `p5_core`

## Requirements
- R1: While reset is held and after it is released, the PC, every register and every stage register are cleared. Every stage register holds a noop, so `halted` is low.
- R2: Instruction fields: opcode in bits 24:22, first source A in 21:19, second field B in 18:16, destination of `add`/`nor` in 2:0, and a signed 16-bit offset in 15:0. Opcodes: add=0, nor=1, lw=2, sw=3, beq=4, jalr=5, halt=6, noop=7. A word with any of bits 31:25 set executes as a noop. `add` writes A+B and `nor` writes ~(A|B) to the destination.
- R3: `lw` loads data word [A + sign-extended offset] into register B. `sw` stores register B to that address.
- R4: `beq` with A equal to B redirects fetch to its own address + 1 + offset. The three younger instructions become noops. A branch not taken changes nothing.
- R5: `jalr` writes its own address + 1 to register B and redirects fetch to the value of register A, squashing younger work in the same way as a taken branch.
- R6: An instruction in decode that reads the register an `lw` in execute will write stalls for exactly one cycle. The PC and decode are held, and a noop enters execute.
- R7: Execute takes an operand from the memory-stage result in preference to the write-back result, and from either in preference to the value read in decode.
- R8: A register written in write-back is seen by a read in decode during the same cycle.
- R9: Once `halt` is in write-back, `halted` stays high and nothing further is written to the PC, registers or data memory, including by instructions that follow the halt.
- R10: The load port writes instruction memory when `load_sel` is 0 and data memory when it is 1, and reads back the selected memory. Words at or above 2^MEM_AW read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_we | input | 1 | Write strobe of the load port |
| load_sel | input | 1 | Load port target: 0 instruction memory, 1 data memory |
| load_addr | input | 16 | Load port word address |
| load_data | input | 32 | Load port write data |
| load_rdata | output | 32 | Read data of the selected memory at load_addr |
| peek_reg | input | 3 | Register index to observe |
| peek_val | output | 32 | Value of register peek_reg |
| halted | output | 1 | High while a halt occupies write-back |

## Verification
A load-use stall and a taken-branch flush can arise in the same cycle. So can a memory-stage store and the freeze caused by `halt` in write-back. The test program sets up both pairs. It puts a `jalr` that depends on the load just before it, which stalls, and then redirects. It also places a `sw` directly after `halt`, so that the store reaches the memory stage in the cycle the halt retires. The outcome is judged from the cycle in which `halted` rises, which counts every stall and flush bubble. It is also judged from the final registers and data words: the squashed and post-halt stores must leave their addresses at zero.

// File: rtl/p5_pkg.sv
package p5_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;
  localparam int REG_AW = 3;
  localparam int OFF_W  = 16;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NOR  = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_JALR = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } op_e;

  // control carried past execute: operation, write enable, destination
  typedef struct packed {
    op_e               op;
    logic              wen;
    logic [REG_AW-1:0] dst;
  } ctl_t;

  localparam logic [WORD_W-1:0] NOOP_WORD = {7'd0, 3'd7, 22'd0};
  localparam ctl_t CTL_NOP = '{op: OP_NOOP, wen: 1'b0, dst: '0};

  function automatic op_e op_of(input logic [WORD_W-1:0] w);
    if (w[31:25] != 7'd0) return OP_NOOP;
    return op_e'(w[24:22]);
  endfunction

  function automatic logic [REG_AW-1:0] fld_a(input logic [WORD_W-1:0] w);
    return w[21:19];
  endfunction

  function automatic logic [REG_AW-1:0] fld_b(input logic [WORD_W-1:0] w);
    return w[18:16];
  endfunction

  function automatic logic [WORD_W-1:0] sext_off(input logic [WORD_W-1:0] w);
    return {{(WORD_W-OFF_W){w[OFF_W-1]}}, w[OFF_W-1:0]};
  endfunction

  function automatic logic uses_a(input op_e op);
    return op inside {OP_ADD, OP_NOR, OP_LW, OP_SW, OP_BEQ, OP_JALR};
  endfunction

  function automatic logic uses_b(input op_e op);
    return op inside {OP_ADD, OP_NOR, OP_SW, OP_BEQ};
  endfunction

  function automatic ctl_t decode(input logic [WORD_W-1:0] w);
    ctl_t c;
    c.op  = op_of(w);
    c.wen = c.op inside {OP_ADD, OP_NOR, OP_LW, OP_JALR};
    c.dst = (c.op inside {OP_ADD, OP_NOR}) ? w[2:0] : w[18:16];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] alu_f(input op_e op, input logic [WORD_W-1:0] a,
                                             input logic [WORD_W-1:0] b,
                                             input logic [WORD_W-1:0] off);
    case (op)
      OP_ADD:        return a + b;
      OP_NOR:        return ~(a | b);
      OP_LW, OP_SW:  return a + off;
      default:       return '0;
    endcase
  endfunction
endpackage

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int NREG = 8,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  output logic [W-1:0]            rd1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd2,
  input  logic [$clog2(NREG)-1:0] ra3,
  output logic [W-1:0]            rd3
);
  localparam int AW = $clog2(NREG);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // write-first: a same-cycle write is visible to the readers
  function automatic logic [W-1:0] rd_wf(input logic [AW-1:0] ra);
    return (we && waddr == ra) ? wdata : regs[ra];
  endfunction

  assign rd1 = rd_wf(ra1);
  assign rd2 = rd_wf(ra2);
  assign rd3 = rd_wf(ra3);
endmodule

// File: rtl/p5_mem.sv
module p5_mem #(
  parameter int AW = 8,
  parameter int IW = 16,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [IW-1:0] ra2,
  output logic [W-1:0]  rd2
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  function automatic logic inside_range(input logic [IW-1:0] a);
    return a[IW-1:AW] == '0;
  endfunction

  always_ff @(posedge clk) begin
    if (we && inside_range(waddr)) mem[waddr[AW-1:0]] <= wdata;
  end

  assign rd1 = inside_range(ra1) ? mem[ra1[AW-1:0]] : '0;
  assign rd2 = inside_range(ra2) ? mem[ra2[AW-1:0]] : '0;
endmodule

// File: rtl/p5_hazard.sv
module p5_hazard
  import p5_pkg::*;
(
  input  op_e               id_op,
  input  logic [REG_AW-1:0] id_ra,
  input  logic [REG_AW-1:0] id_rb,
  input  op_e               ex_op,
  input  logic [REG_AW-1:0] ex_ra,
  input  logic [REG_AW-1:0] ex_rb,
  input  logic [WORD_W-1:0] ex_va,
  input  logic [WORD_W-1:0] ex_vb,
  input  ctl_t              exm_ctl,
  input  logic [WORD_W-1:0] exm_val,
  input  ctl_t              mwb_ctl,
  input  logic [WORD_W-1:0] mwb_val,
  output logic              stall,
  output logic [WORD_W-1:0] opa,
  output logic [WORD_W-1:0] opb
);
  logic exm_fwd_ok;
  assign exm_fwd_ok = exm_ctl.wen && exm_ctl.op != OP_LW;

  function automatic logic [WORD_W-1:0] pick(input logic [REG_AW-1:0] r,
                                            input logic [WORD_W-1:0] own);
    if (exm_fwd_ok && exm_ctl.dst == r) return exm_val;
    if (mwb_ctl.wen && mwb_ctl.dst == r) return mwb_val;
    return own;
  endfunction

  assign opa = pick(ex_ra, ex_va);
  assign opb = pick(ex_rb, ex_vb);

  // lw in execute writes its B field
  assign stall = (ex_op == OP_LW) &&
                 ((uses_a(id_op) && id_ra == ex_rb) || (uses_b(id_op) && id_rb == ex_rb));
endmodule

// File: rtl/p5_core.sv
module p5_core
  import p5_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic              load_sel,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic [WORD_W-1:0] load_rdata,
  input  logic [REG_AW-1:0] peek_reg,
  output logic [WORD_W-1:0] peek_val,
  output logic              halted
);
  localparam int PAD_W = WORD_W - ADDR_W;

  // stage registers
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ifid_ir;
  logic [ADDR_W-1:0] ifid_pc1;
  logic [WORD_W-1:0] idex_ir, idex_va, idex_vb;
  logic [ADDR_W-1:0] idex_pc1;
  ctl_t              exm_ctl;
  logic [WORD_W-1:0] exm_alu, exm_vb;
  logic [ADDR_W-1:0] exm_pc1, exm_tgt;
  logic              exm_eq;
  ctl_t              mwb_ctl;
  logic [WORD_W-1:0] mwb_val;

  // named internal events
  logic              stall, take, rf_we, dm_core_we;
  op_e               ifid_op, idex_op;
  ctl_t              ex_ctl;
  logic [WORD_W-1:0] fetch_ir, id_va, id_vb, ex_a, ex_b, ex_alu, exm_res, ld_data;
  logic [WORD_W-1:0] i_peek, d_peek;
  logic [ADDR_W-1:0] ex_tgt;

  assign ifid_op    = op_of(ifid_ir);
  assign idex_op    = op_of(idex_ir);
  assign ex_ctl     = decode(idex_ir);
  assign halted     = mwb_ctl.op == OP_HALT;
  assign take       = (exm_ctl.op == OP_BEQ && exm_eq) || exm_ctl.op == OP_JALR;
  assign rf_we      = mwb_ctl.wen && !halted;
  assign dm_core_we = exm_ctl.op == OP_SW && !halted;
  assign exm_res    = (exm_ctl.op == OP_JALR) ? {{PAD_W{1'b0}}, exm_pc1} : exm_alu;
  assign ex_alu     = alu_f(idex_op, ex_a, ex_b, sext_off(idex_ir));
  assign ex_tgt     = (idex_op == OP_JALR) ? ex_a[ADDR_W-1:0] : idex_pc1 + idex_ir[ADDR_W-1:0];
  assign load_rdata = load_sel ? d_peek : i_peek;

  p5_mem #(.AW(MEM_AW), .IW(ADDR_W), .W(WORD_W)) u_imem (
    .clk(clk), .we(load_we && !load_sel), .waddr(load_addr), .wdata(load_data),
    .ra1(pc_q), .rd1(fetch_ir), .ra2(load_addr), .rd2(i_peek));

  p5_mem #(.AW(MEM_AW), .IW(WORD_W), .W(WORD_W)) u_dmem (
    .clk(clk), .we(dm_core_we || (load_we && load_sel)),
    .waddr((load_we && load_sel) ? {{PAD_W{1'b0}}, load_addr} : exm_alu),
    .wdata((load_we && load_sel) ? load_data : exm_vb),
    .ra1(exm_alu), .rd1(ld_data), .ra2({{PAD_W{1'b0}}, load_addr}), .rd2(d_peek));

  p5_regfile #(.NREG(NREG), .W(WORD_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(mwb_ctl.dst), .wdata(mwb_val),
    .ra1(fld_a(ifid_ir)), .rd1(id_va), .ra2(fld_b(ifid_ir)), .rd2(id_vb),
    .ra3(peek_reg), .rd3(peek_val));

  p5_hazard u_hz (
    .id_op(ifid_op), .id_ra(fld_a(ifid_ir)), .id_rb(fld_b(ifid_ir)),
    .ex_op(idex_op), .ex_ra(fld_a(idex_ir)), .ex_rb(fld_b(idex_ir)),
    .ex_va(idex_va), .ex_vb(idex_vb),
    .exm_ctl(exm_ctl), .exm_val(exm_res), .mwb_ctl(mwb_ctl), .mwb_val(mwb_val),
    .stall(stall), .opa(ex_a), .opb(ex_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ifid_ir  <= NOOP_WORD;
      ifid_pc1 <= '0;
      idex_ir  <= NOOP_WORD;
      idex_pc1 <= '0;
      idex_va  <= '0;
      idex_vb  <= '0;
      exm_ctl  <= CTL_NOP;
      exm_alu  <= '0;
      exm_vb   <= '0;
      exm_pc1  <= '0;
      exm_tgt  <= '0;
      exm_eq   <= 1'b0;
      mwb_ctl  <= CTL_NOP;
      mwb_val  <= '0;
    end else if (!halted) begin
      // fetch
      if (take) begin
        pc_q    <= exm_tgt;
        ifid_ir <= NOOP_WORD;
      end else if (!stall) begin
        pc_q     <= pc_q + 1'b1;
        ifid_ir  <= fetch_ir;
        ifid_pc1 <= pc_q + 1'b1;
      end
      // decode
      if (take || stall) begin
        idex_ir <= NOOP_WORD;
      end else begin
        idex_ir  <= ifid_ir;
        idex_pc1 <= ifid_pc1;
        idex_va  <= id_va;
        idex_vb  <= id_vb;
      end
      // execute
      if (take) begin
        exm_ctl <= CTL_NOP;
      end else begin
        exm_ctl <= ex_ctl;
        exm_alu <= ex_alu;
        exm_vb  <= ex_b;
        exm_pc1 <= idex_pc1;
        exm_tgt <= ex_tgt;
        exm_eq  <= ex_a == ex_b;
      end
      // memory
      mwb_ctl <= exm_ctl;
      mwb_val <= (exm_ctl.op == OP_LW) ? ld_data : exm_res;
    end
  end
endmodule

// File: rtl/p5_core_chk.sv
module p5_core_chk
  import p5_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc,
  input logic              stall,
  input logic              take,
  input logic              halted,
  input logic              rf_we,
  input logic              dm_we,
  input op_e               ifid_op,
  input op_e               idex_op,
  input op_e               exm_op
);
  assert_stall_holds_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !take && !halted |=> $stable(pc));

  assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !take && !halted |=> idex_op == OP_NOOP);

  assert_redirect_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !halted |=> ifid_op == OP_NOOP && idex_op == OP_NOOP && exm_op == OP_NOOP);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc));

  assert_halt_no_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !rf_we && !dm_we);
endmodule

bind p5_core p5_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc_q), .stall(stall), .take(take), .halted(halted),
  .rf_we(rf_we), .dm_we(dm_core_we), .ifid_op(ifid_op), .idex_op(idex_op),
  .exm_op(exm_ctl.op));

// File: tb/p5_core_test.sv
`timescale 1ns/100ps
module p5_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 1'b0;
  logic        load_sel = 1'b0;
  logic [15:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] load_rdata;
  logic [2:0]  peek_reg = '0;
  logic [31:0] peek_val;
  logic        halted;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  p5_core uut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_sel(load_sel), .load_addr(load_addr),
    .load_data(load_data), .load_rdata(load_rdata), .peek_reg(peek_reg), .peek_val(peek_val),
    .halted(halted));

  // expected final state of program one: {kind 0=register 1=data word, index, value, tag}
  localparam int NEXP = 14;
  localparam logic [52:0] EXP [NEXP] = '{
    {1'b0, 16'd1,  32'd5,        4'd3},
    {1'b0, 16'd2,  32'd7,        4'd3},
    {1'b0, 16'd3,  32'd34,       4'd8},
    {1'b0, 16'd4,  32'hFFFFFFD8, 4'd2},
    {1'b0, 16'd5,  32'd34,       4'd7},
    {1'b0, 16'd6,  32'd15,       4'd3},
    {1'b0, 16'd7,  32'd13,       4'd5},
    {1'b0, 16'd0,  32'd0,        4'd2},
    {1'b1, 16'd20, 32'd34,       4'd3},
    {1'b1, 16'd21, 32'd0,        4'd4},
    {1'b1, 16'd22, 32'd0,        4'd5},
    {1'b1, 16'd12, 32'd7,        4'd3},
    {1'b1, 16'd23, 32'd0,        4'd9},
    {1'b1, 16'd10, 32'd5,        4'd10}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] enc(input int op, input int a, input int b, input int low);
    return {7'd0, op[2:0], a[2:0], b[2:0], low[15:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input int addr, input logic [31:0] data);
    load_we = 1'b1; load_sel = sel; load_addr = addr[15:0]; load_data = data;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic rd_mem(input logic sel, input int addr, output logic [31:0] v);
    load_sel = sel; load_addr = addr[15:0];
    #0.5 v = load_rdata;
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    peek_reg = r[2:0];
    #0.5 v = peek_val;
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    rst_n = 1'b1;
    while (!halted && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 1000) check("watchdog run", 32'd0, 32'd1);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int          cyc;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      wr(1'b0, i, enc(7, 0, 0, 0));
      wr(1'b1, i, 32'd0);
    end
    wr(1'b1, 10, 32'd5);
    wr(1'b1, 11, 32'd7);
    wr(1'b1, 12, 32'd15);
    // program one
    wr(1'b0, 0,  enc(2, 0, 1, 10));     // lw  r1 <- d[10]
    wr(1'b0, 1,  enc(2, 0, 2, 11));     // lw  r2 <- d[11]
    wr(1'b0, 2,  enc(0, 1, 2, 3));      // add r3 = r1+r2, load-use stall
    wr(1'b0, 3,  enc(0, 3, 1, 3));      // r3 = 17
    wr(1'b0, 4,  enc(0, 3, 3, 3));      // r3 = 34
    wr(1'b0, 5,  enc(0, 3, 0, 5));      // r5 = newest r3 = 34
    wr(1'b0, 6,  enc(1, 5, 2, 4));      // r4 = ~(34|7)
    wr(1'b0, 7,  enc(3, 0, 5, 20));     // d[20] = r5
    wr(1'b0, 8,  enc(4, 0, 0, 2));      // beq taken -> 11
    wr(1'b0, 9,  enc(0, 1, 1, 6));      // squashed
    wr(1'b0, 10, enc(3, 0, 1, 21));     // squashed
    wr(1'b0, 11, enc(2, 0, 6, 12));     // r6 = 15
    wr(1'b0, 12, enc(5, 6, 7, 0));      // jalr r7 = 13, -> 15, load-use stall
    wr(1'b0, 13, enc(0, 1, 1, 1));      // squashed
    wr(1'b0, 14, enc(3, 0, 1, 22));     // squashed
    wr(1'b0, 15, enc(4, 1, 2, 5));      // beq not taken
    wr(1'b0, 16, enc(3, 7, 2, 16'hFFFF)); // d[12] = r2
    wr(1'b0, 17, enc(6, 0, 0, 0));      // halt
    wr(1'b0, 18, enc(3, 0, 1, 23));     // behind halt
    wr(1'b0, 19, enc(0, 1, 1, 1));      // behind halt

    // R1: reset state
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    rd_reg(3, v);
    check("R1 register cleared", v, 32'd0);
    // R10: load port readback and range
    rd_mem(1'b0, 17, v);
    check("R10 instruction readback", v, enc(6, 0, 0, 0));
    rd_mem(1'b1, 16'h0100, v);
    check("R10 out-of-range read", v, 32'd0);

    @(negedge clk);
    run(cyc);
    // R4 R6: two stalls and two redirects set when halted rises
    check("R6 R4 cycles to halt", cyc, 32'd25);

    for (int k = 0; k < NEXP; k++) begin
      if (EXP[k][52]) rd_mem(1'b1, int'(EXP[k][51:36]), v);
      else            rd_reg(int'(EXP[k][51:36]), v);
      check({tag_name(EXP[k][3:0]), " final state"}, v, EXP[k][35:4]);
    end

    // R9: stays frozen
    repeat (5) @(negedge clk);
    check("R9 halted sticky", {31'd0, halted}, 32'd1);
    rd_mem(1'b1, 23, v);
    check("R9 no store after halt", v, 32'd0);
    rd_reg(1, v);
    check("R9 no register write after halt", v, 32'd5);

    // program two: upper opcode bits set -> noop
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 halted low after re-reset", {31'd0, halted}, 32'd0);
    rd_reg(7, v);
    check("R1 registers cleared on re-reset", v, 32'd0);
    wr(1'b0, 0, enc(2, 0, 1, 10));
    wr(1'b0, 1, enc(0, 1, 1, 2) | 32'h8000_0000);
    wr(1'b0, 2, enc(6, 0, 0, 0));
    @(negedge clk);
    run(cyc);
    check("R1 cycles to halt from PC 0", cyc, 32'd6);
    rd_reg(2, v);
    check("R2 upper bits make noop", v, 32'd0);
    rd_reg(1, v);
    check("R3 load after re-reset", v, 32'd5);
    summary();
  end
endmodule